// File: doc/BRIEF.md
# Expanding Opcode Instruction Decoder

This block classifies a fixed 16-bit instruction word whose opcode grows in length. It also pulls out the register operand fields. The word is treated as four 4-bit nibbles. An all-ones value in a leading nibble does not select an instruction. Instead it passes decoding on to the next nibble, so a field that would otherwise name a register becomes more opcode bits. Four classes result: three-operand, two-operand, one-operand and zero-operand instructions. Together they cover all 65536 words with no illegal encoding.

For each word the decoder reports the operand count as the class code and an opcode index that is numbered within that class. It also gives three register fields and a mask that marks which of those fields carry a real operand. A parameter selects between a purely combinational result and a result held in an output register, with a latency of one clock. Fetch, execution and the register file belong to neighbouring blocks.

Top module: `expand_op_decoder`

## Requirements
- R1: A word whose top nibble (bits 15:12) is 0 through 14 decodes as class code 3. The opcode index equals that nibble. regA, regB and regC carry bits 11:8, 7:4 and 3:0, and regValid is 3'b111 (bit 0 marks regA, bit 1 regB, bit 2 regC).
- R2: A word whose top nibble is 15 and whose bits 11:8 are 0 through 13 decodes as class code 2. The opcode index equals bits 11:8, regA carries bits 7:4, regB carries bits 3:0, and regValid is 3'b011.
- R3: A word starting 1111 1110 decodes as class code 1. The opcode index is bits 7:4 (0 through 15), regA carries bits 3:0, and regValid is 3'b001.
- R4: A word starting 1111 1111 whose bits 7:4 are 0 through 14 decodes as class code 1. The opcode index is 16 plus bits 7:4, which gives 16 through 30, regA carries bits 3:0, and regValid is 3'b001.
- R5: A word starting 1111 1111 1111 decodes as class code 0. The opcode index equals bits 3:0, and regValid is 3'b000.
- R6: Every register field whose regValid bit is clear reads zero, and opcode index bit 4 is one only for the R4 group.
- R7: The number of set regValid bits always equals the class code.
- R8: With REG_OUT=1 (the default), the decoded outputs for a word appear after the next rising clock edge and do not change before that edge. With REG_OUT=0 they follow the word within the same cycle.
- R9: While rstN is low, the registered outputs all read zero.
- R10: Each of the 65536 words falls into exactly one class. Over the whole space, the class counts are 61440 words with three operands, 3584 with two, 496 with one and 16 with none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous active-low reset |
| instrWord | input | 16 | Instruction word to decode |
| opClass | output | 2 | Operand count: 3, 2, 1 or 0 |
| opIndex | output | 5 | Opcode number within the class |
| regA | output | 4 | First register operand |
| regB | output | 4 | Second register operand |
| regC | output | 4 | Third register operand |
| regValid | output | 3 | Operand-present mask, bit 0 for regA |

## Verification
The clocked checks assume that instrWord holds a known value at every edge after reset is released, because an unknown nibble would make the class strobes meaningless. The one-hot strobe check is skipped while the word holds unknown bits. The stimulus drives a defined word from reset onward. Each new word is applied on the falling edge, so every word is stable across the rising edge that captures it. The sweep visits every value exactly once, in increasing order.

// File: rtl/ecdec_pkg.sv
package ecdec_pkg;
  localparam int NIB_W   = 4;
  localparam int NUM_NIB = 4;
  localparam int WORD_W  = NIB_W * NUM_NIB;
  localparam int IDX_W   = NIB_W + 1;
  localparam int NUM_OPS = 3;
  localparam int CLS_W   = 2;
  localparam logic [NIB_W-1:0] ESC_NIB  = '1;
  localparam logic [NIB_W-1:0] ONE_GRP  = ESC_NIB - 1'b1;

  typedef struct packed {
    logic selThree;
    logic selTwo;
    logic selOneLo;
    logic selOneHi;
    logic selZero;
  } dcdStrobesT;

  typedef struct packed {
    logic [CLS_W-1:0]   cls;
    logic [IDX_W-1:0]   opIdx;
    logic [NIB_W-1:0]   opA;
    logic [NIB_W-1:0]   opB;
    logic [NIB_W-1:0]   opC;
    logic [NUM_OPS-1:0] opValid;
  } dcdResultT;
endpackage

// File: rtl/ecdec_ctrl.sv
module ecdec_ctrl
  import ecdec_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output dcdStrobesT        strobes
);
  logic [NUM_NIB-1:0] nibOnes;
  logic               secondIsOneGrp;

  // escape detection per nibble
  for (genvar i = 0; i < NUM_NIB; i++) begin : g_esc
    assign nibOnes[i] = (instr[i*NIB_W +: NIB_W] == ESC_NIB);
  end

  assign secondIsOneGrp = (instr[2*NIB_W +: NIB_W] == ONE_GRP);

  always_comb begin
    strobes          = '0;
    strobes.selThree = !nibOnes[3];
    strobes.selTwo   = nibOnes[3] && !nibOnes[2] && !secondIsOneGrp;
    strobes.selOneLo = nibOnes[3] && secondIsOneGrp;
    strobes.selOneHi = nibOnes[3] && nibOnes[2] && !nibOnes[1];
    strobes.selZero  = nibOnes[3] && nibOnes[2] && nibOnes[1];
  end
endmodule

// File: rtl/ecdec_datapath.sv
module ecdec_datapath
  import ecdec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] instr,
  input  dcdStrobesT        strobes,
  output dcdResultT         result
);
  logic [NIB_W-1:0] nib [NUM_NIB];
  dcdResultT        nxt;

  for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
    assign nib[i] = instr[i*NIB_W +: NIB_W];
  end

  always_comb begin
    nxt = '0;
    if (strobes.selThree) begin
      nxt.cls     = CLS_W'(3);
      nxt.opIdx   = {1'b0, nib[3]};
      nxt.opA     = nib[2];
      nxt.opB     = nib[1];
      nxt.opC     = nib[0];
      nxt.opValid = 3'b111;
    end else if (strobes.selTwo) begin
      nxt.cls     = CLS_W'(2);
      nxt.opIdx   = {1'b0, nib[2]};
      nxt.opA     = nib[1];
      nxt.opB     = nib[0];
      nxt.opValid = 3'b011;
    end else if (strobes.selOneLo || strobes.selOneHi) begin
      nxt.cls     = CLS_W'(1);
      nxt.opIdx   = {strobes.selOneHi, nib[1]};
      nxt.opA     = nib[0];
      nxt.opValid = 3'b001;
    end else if (strobes.selZero) begin
      nxt.opIdx   = {1'b0, nib[0]};
    end
  end

  // R10
  always_comb begin
    if (rstN && !$isunknown(instr)) begin
      strobeOnehot_chk: assert ($onehot(strobes));
    end
  end

  if (REG_OUT) begin : g_reg
    dcdResultT resQ;
    logic      primed;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resQ   <= '0;
        primed <= 1'b0;
      end else begin
        resQ   <= nxt;
        primed <= 1'b1;
      end
    end
    assign result = resQ;

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rstN)
      (primed && $past(instr[WORD_W-1 -: NIB_W]) != ESC_NIB) |->
        (result.cls == CLS_W'(3) &&
         result.opIdx == {1'b0, $past(instr[WORD_W-1 -: NIB_W])}));
  end else begin : g_comb
    assign result = nxt;
  end

  // R7
  maskCount_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(result.opValid) == int'(result.cls));

  // R6
  unusedZero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (result.opValid[0] || result.opA == '0) &&
    (result.opValid[1] || result.opB == '0) &&
    (result.opValid[2] || result.opC == '0));

  // R4
  highIdx_chk: assert property (@(posedge clk) disable iff (!rstN)
    result.opIdx[IDX_W-1] |->
      (result.cls == CLS_W'(1) && result.opIdx[IDX_W-2:0] != ESC_NIB));
endmodule

// File: rtl/expand_op_decoder.sv
module expand_op_decoder
  import ecdec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] instrWord,
  output logic [CLS_W-1:0]  opClass,
  output logic [IDX_W-1:0]  opIndex,
  output logic [NIB_W-1:0]  regA,
  output logic [NIB_W-1:0]  regB,
  output logic [NIB_W-1:0]  regC,
  output logic [NUM_OPS-1:0] regValid
);
  dcdStrobesT strobes;
  dcdResultT  result;

  ecdec_ctrl u_ctrl (
    .instr   (instrWord),
    .strobes (strobes)
  );

  ecdec_datapath #(.REG_OUT(REG_OUT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .instr   (instrWord),
    .strobes (strobes),
    .result  (result)
  );

  assign opClass  = result.cls;
  assign opIndex  = result.opIdx;
  assign regA     = result.opA;
  assign regB     = result.opB;
  assign regC     = result.opC;
  assign regValid = result.opValid;
endmodule

// File: tb/tb_expand_op_decoder.sv
module tb_expand_op_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] instrWord = 16'h0000;
  logic [1:0]  opClass;
  logic [4:0]  opIndex;
  logic [3:0]  regA, regB, regC;
  logic [2:0]  regValid;

  int checks = 0;
  int errors = 0;
  int actCount [4];
  logic [21:0] expQ [$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  expand_op_decoder dut (
    .clk(clk), .rstN(rstN), .instrWord(instrWord),
    .opClass(opClass), .opIndex(opIndex),
    .regA(regA), .regB(regB), .regC(regC), .regValid(regValid)
  );

  // expected {class, index, A, B, C, mask} from the requirements
  function automatic logic [21:0] expectOf(input logic [15:0] w);
    logic [3:0] n3, n2, n1, n0;
    {n3, n2, n1, n0} = w;
    if (n3 != 4'hF)      return {2'd3, 1'b0, n3, n2, n1, n0, 3'b111};
    else if (n2 <= 4'd13) return {2'd2, 1'b0, n2, n1, n0, 4'h0, 3'b011};
    else if (n2 == 4'hE) return {2'd1, 1'b0, n1, n0, 8'h00, 3'b001};
    else if (n1 != 4'hF) return {2'd1, 1'b1, n1, n0, 8'h00, 3'b001};
    else                 return {2'd0, 1'b0, n0, 12'h000, 3'b000};
  endfunction

  function automatic string tagOf(input logic [21:0] e);
    case (e[21:20])
      2'd3: return "R1";
      2'd2: return "R2";
      2'd1: return e[19] ? "R4" : "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // driver: one word per cycle, expected item queued
  task automatic drive(input logic [15:0] w);
    @(negedge clk);
    instrWord = w;
    expQ.push_back(expectOf(w));
  endtask

  // monitor: one registered result per rising edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      logic [21:0] exp, act;
      exp = expQ.pop_front();
      act = {opClass, opIndex, regA, regB, regC, regValid};
      check(act == exp, tagOf(exp), 32'(act), 32'(exp));
      // R6: fields not flagged valid read zero
      check(((regValid[0] || regA == 0) && (regValid[1] || regB == 0) &&
             (regValid[2] || regC == 0)), "R6", 32'(act), 32'(exp));
      // R7: mask population equals class
      check($countones(regValid) == int'(opClass), "R7",
            32'(regValid), 32'(opClass));
      actCount[opClass]++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) actCount[i] = 0;
    instrWord = 16'h1234;
    repeat (3) @(negedge clk);
    // R9: reset state
    check({opClass, opIndex, regA, regB, regC, regValid} == 22'd0, "R9",
          32'({opClass, opIndex, regA, regB, regC, regValid}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R8: new word not visible before the edge, visible after
    instrWord = 16'hFFF5;
    #1;
    check(opClass == 2'd3 && opIndex == 5'd1, "R8", 32'(opIndex), 32'd1);
    @(posedge clk);
    #2;
    check(opClass == 2'd0 && opIndex == 5'd5, "R8", 32'(opIndex), 32'd5);
    for (int i = 0; i < 4; i++) actCount[i] = 0;
    // full sweep through the scoreboard
    for (int w = 0; w < 65536; w++) drive(16'(w));
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    // R10: class populations
    check(actCount[3] == 61440, "R10", 32'(actCount[3]), 32'd61440);
    check(actCount[2] == 3584,  "R10", 32'(actCount[2]), 32'd3584);
    check(actCount[1] == 496,   "R10", 32'(actCount[1]), 32'd496);
    check(actCount[0] == 16,    "R10", 32'(actCount[0]), 32'd16);
    done = 1'b1;
    summary();
  end
endmodule